// File: doc/BRIEF.md
# PCIe MSI Capture Controller

This block sits beside the inbound write path of a PCIe root port. Software programs a 64-bit message address and a 32-bit vector enable through a small register window. After that, every inbound memory write that lands on that address with a 4-byte length is taken by the block. The low five bits of the write data pick one bit of a 32-bit status register, and that bit is set if its enable bit is 1. All other inbound accesses are flagged as pass-through so that the normal inbound path forwards them. This includes reads of the message address, writes of any other length, writes to other addresses, and every access while the enable register is zero.

A single level-sensitive interrupt line goes toward the CPU. It is raised by a captured message that leaves at least one unmasked status bit set. It stays high until software has toggled the whole status register back to zero, because a status write XORs its data into status. Masked bits still collect and still read back; they only keep a capture from raising the line.

Top module: `msi_catcher`

## Requirements
- R1: Registers sit at byte offsets 0x820 (message address bits 31:0), 0x824 (message address bits 63:32), 0x828 (enable), 0x82C (mask) and 0x830 (status). A register write takes effect at the next clock edge. A read strobe returns the value on `reg_rdata` after the next clock edge.
- R2: An access is claimed only when all of these hold: it is valid, it is a write (`in_write`=1), its full 64-bit address equals the message address, and its `in_len` is 4. One edge later, `in_claim` is 1 for a claimed access and `in_pass` is 1 for every other valid access. Both are 0 when no access was presented.
- R3: A claimed write sets status bit `in_data[4:0]` when the same enable bit is 1. Data bits 31:5 are ignored. If the selected enable bit is 0, status is unchanged even though the write is claimed. A repeated vector leaves status as it was.
- R4: The interrupt goes high on the edge that captures a message, if status AND NOT mask is then nonzero. A capture that sets only masked bits does not raise it.
- R5: A write to offset 0x830 replaces status with status XOR data. The interrupt falls only when the result is all zeros. A status write never raises the interrupt.
- R6: While the enable register is zero, writes to the message address are not claimed and are passed through.
- R7: Reads (`in_write`=0) of the message address are always passed through and never change status.
- R8: Writes to the message address with `in_len` other than 4 are passed through and never change status.
- R9: After reset, all registers read zero and `irq`, `in_claim` and `in_pass` are low.
- R10: Masked status bits stay readable in status. Reads of offsets other than the five registers return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_ofs | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| in_valid | input | 1 | Inbound access present this cycle |
| in_write | input | 1 | 1 = memory write, 0 = memory read |
| in_len | input | 3 | Access length in bytes |
| in_addr | input | 64 | Inbound access address |
| in_data | input | 32 | Inbound write data |
| in_claim | output | 1 | Access presented last cycle was taken as a message |
| in_pass | output | 1 | Access presented last cycle must be forwarded |
| irq | output | 1 | Level interrupt toward the CPU |

## Verification
Every result is registered, so status, `irq`, `in_claim` and `in_pass` change on the edge that samples the stimulus. `reg_rdata` is due on the edge that samples the read strobe. The bench applies each stimulus on a falling edge and holds it across one rising edge. It then samples the outputs on the next falling edge, exactly one edge after the stimulus. Status is checked through a separate register read that starts only after the capture has completed.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;
  localparam int OFS_W = 12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ADDR_LO,
    SEL_ADDR_HI,
    SEL_ENABLE,
    SEL_MASK,
    SEL_STATUS
  } reg_sel_e;

  // Offset map; the status offset is what gives a write its XOR meaning.
  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    case (ofs)
      12'h820: return SEL_ADDR_LO;
      12'h824: return SEL_ADDR_HI;
      12'h828: return SEL_ENABLE;
      12'h82C: return SEL_MASK;
      12'h830: return SEL_STATUS;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/msi_cfg_regs.sv
`timescale 1ns/1ps
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  reg_sel_e              sel,
  input  logic [DATA_W-1:0]     wdata,
  output logic [2*DATA_W-1:0]   msg_addr,
  output logic [DATA_W-1:0]     enable,
  output logic [DATA_W-1:0]     mask
);
  localparam int HALVES = 2;

  logic [DATA_W-1:0] addr_half [HALVES];

  // Each half of the message address is its own register word.
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam reg_sel_e HSEL = (h == 0) ? SEL_ADDR_LO : SEL_ADDR_HI;
    always_ff @(posedge clk) begin
      if (rst)                        addr_half[h] <= '0;
      else if (wr_en && sel == HSEL)  addr_half[h] <= wdata;
    end
    assign msg_addr[h*DATA_W +: DATA_W] = addr_half[h];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      mask   <= '0;
    end else if (wr_en) begin
      if (sel == SEL_ENABLE) enable <= wdata;
      if (sel == SEL_MASK)   mask   <= wdata;
    end
  end
endmodule

// File: rtl/msi_window_match.sv
`timescale 1ns/1ps
module msi_window_match #(
  parameter int DATA_W = 32,
  parameter int MSG_LEN = 4,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_write,
  input  logic [2:0]        in_len,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [DATA_W-1:0] enable,
  output logic              cap_fire,
  output logic [DATA_W-1:0] cap_vec,
  output logic              claim_q,
  output logic              pass_q
);
  localparam logic [DATA_W-1:0] IDX_MOD = DATA_W[DATA_W-1:0];

  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] onehot;

  // Only the low index bits of the message data pick the vector.
  assign bit_idx = IDX_W'(in_data % IDX_MOD);

  for (genvar g = 0; g < DATA_W; g++) begin : g_dec
    assign onehot[g] = (bit_idx == IDX_W'(g));
  end

  assign cap_fire = in_valid && in_write && (in_addr == msg_addr)
                 && (in_len == 3'(MSG_LEN)) && (|enable);
  assign cap_vec  = onehot & enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      claim_q <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      claim_q <= cap_fire;
      pass_q  <= in_valid && !cap_fire;
    end
  end
endmodule

// File: rtl/msi_status_core.sv
`timescale 1ns/1ps
module msi_status_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_fire,
  input  logic [DATA_W-1:0] cap_vec,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  logic [DATA_W-1:0] nxt;

  // A software toggle is applied first, then a same-cycle capture ORs in.
  always_comb begin
    nxt = stat_wr ? (status ^ wdata) : status;
    if (cap_fire) nxt = nxt | cap_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= nxt;
      if (cap_fire && |(nxt & ~mask)) irq <= 1'b1;
      else if (stat_wr && nxt == '0)  irq <= 1'b0;
    end
  end
endmodule

// File: rtl/msi_catcher.sv
`timescale 1ns/1ps
module msi_catcher
  import msi_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [OFS_W-1:0]  reg_ofs,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              in_valid,
  input  logic              in_write,
  input  logic [2:0]        in_len,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_claim,
  output logic              in_pass,
  output logic              irq
);
  reg_sel_e          sel;
  logic              stat_wr;
  logic [ADDR_W-1:0] msg_addr;
  logic [DATA_W-1:0] enable_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] status_q;
  logic              cap_fire;
  logic [DATA_W-1:0] cap_vec;

  assign sel     = decode_ofs(reg_ofs);
  assign stat_wr = reg_wr && (sel == SEL_STATUS);

  msi_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .sel(sel), .wdata(reg_wdata),
    .msg_addr(msg_addr), .enable(enable_q), .mask(mask_q)
  );

  msi_window_match #(.DATA_W(DATA_W)) u_match (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_write(in_write),
    .in_len(in_len), .in_addr(in_addr), .in_data(in_data),
    .msg_addr(msg_addr), .enable(enable_q),
    .cap_fire(cap_fire), .cap_vec(cap_vec),
    .claim_q(in_claim), .pass_q(in_pass)
  );

  msi_status_core #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .cap_fire(cap_fire), .cap_vec(cap_vec),
    .stat_wr(stat_wr), .wdata(reg_wdata), .mask(mask_q),
    .status(status_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (sel)
        SEL_ADDR_LO: reg_rdata <= msg_addr[DATA_W-1:0];
        SEL_ADDR_HI: reg_rdata <= msg_addr[ADDR_W-1:DATA_W];
        SEL_ENABLE:  reg_rdata <= enable_q;
        SEL_MASK:    reg_rdata <= mask_q;
        SEL_STATUS:  reg_rdata <= status_q;
        default:     reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/msi_catcher_chk.sv
`timescale 1ns/1ps
module msi_catcher_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_claim,
  input logic              in_pass,
  input logic [DATA_W-1:0] enable_q,
  input logic              cap_fire,
  input logic              stat_wr,
  input logic [DATA_W-1:0] status_q,
  input logic              irq
);
  assert_claim_pass_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(in_claim && in_pass));

  assert_access_flagged_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rst) |=> (in_claim || in_pass));

  assert_no_claim_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enable_q == '0) |=> !in_claim);

  assert_irq_rise_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(cap_fire));

  assert_irq_fall_zero_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> (status_q == '0));

  assert_status_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!rst && !stat_wr && !cap_fire) |=> $stable(status_q));
endmodule

bind msi_catcher msi_catcher_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_claim(in_claim),
  .in_pass(in_pass), .enable_q(enable_q), .cap_fire(cap_fire),
  .stat_wr(stat_wr), .status_q(status_q), .irq(irq)
);

// File: tb/msi_catcher_bench.sv
`timescale 1ns/1ps
module msi_catcher_bench;
  localparam logic [63:0] MSG = 64'h0000_0001_FEE0_0000;
  localparam int VW = 71;
  localparam int NV = 9;
  // {addr_kind[1:0], write, len[2:0], data[31:0], exp_claim, exp_status[31:0]}
  // addr_kind: 0 = message address, 1 = high word differs, 2 = low word + 4
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 1'b1, 3'd4, 32'd3,     1'b1, 32'h0000_0008},  // R3 basic vector
    {2'd0, 1'b1, 3'd4, 32'h25,    1'b1, 32'h0000_0028},  // R3 upper bits ignored
    {2'd0, 1'b1, 3'd4, 32'd20,    1'b1, 32'h0000_0028},  // R3 bit not enabled
    {2'd0, 1'b1, 3'd2, 32'd0,     1'b0, 32'h0000_0028},  // R8 short write
    {2'd0, 1'b0, 3'd4, 32'd1,     1'b0, 32'h0000_0028},  // R7 read
    {2'd1, 1'b1, 3'd4, 32'd1,     1'b0, 32'h0000_0028},  // R2 high word miss
    {2'd2, 1'b1, 3'd4, 32'd1,     1'b0, 32'h0000_0028},  // R2 low word miss
    {2'd0, 1'b1, 3'd4, 32'd0,     1'b1, 32'h0000_0029},  // R3 bit zero
    {2'd0, 1'b1, 3'd4, 32'd3,     1'b1, 32'h0000_0029}   // R3 repeat vector
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_ofs = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0, in_write = 1'b0;
  logic [2:0]  in_len = '0;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        in_claim, in_pass, irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  msi_catcher u_msi_catcher (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_write(in_write), .in_len(in_len), .in_addr(in_addr), .in_data(in_data),
    .in_claim(in_claim), .in_pass(in_pass), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] ofs, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_ofs = ofs; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] ofs, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_ofs = ofs;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic snoop(input logic [63:0] a, input logic w, input logic [2:0] len,
                       input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_write = w; in_len = len; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 irq", {63'd0, irq}, 64'd0);
    check("R9 claim/pass", {62'd0, in_claim, in_pass}, 64'd0);
    reg_read(12'h820, rd); check("R9 addr lo", {32'd0, rd}, 64'd0);
    reg_read(12'h828, rd); check("R9 enable", {32'd0, rd}, 64'd0);
    reg_read(12'h830, rd); check("R9 status", {32'd0, rd}, 64'd0);

    // R1 programming and readback
    reg_write(12'h820, MSG[31:0]);
    reg_write(12'h824, MSG[63:32]);
    reg_write(12'h828, 32'h0000_FFFF);
    reg_write(12'h82C, 32'h0);
    reg_read(12'h820, rd); check("R1 addr lo", {32'd0, rd}, {32'd0, MSG[31:0]});
    reg_read(12'h824, rd); check("R1 addr hi", {32'd0, rd}, {32'd0, MSG[63:32]});
    reg_read(12'h828, rd); check("R1 enable", {32'd0, rd}, 64'h0000_FFFF);

    // Vector table: R2 R3 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;
      logic [63:0] a;
      k = VEC[i][70:69];
      a = (k == 2'd0) ? MSG : (k == 2'd1) ? (MSG ^ 64'h1_0000_0000) : (MSG + 64'd4);
      snoop(a, VEC[i][68], VEC[i][67:65], VEC[i][64:33]);
      check("R2 claim", {63'd0, in_claim}, {63'd0, VEC[i][32]});
      check("R2 pass", {63'd0, in_pass}, {63'd0, !VEC[i][32]});
      reg_read(12'h830, rd);
      check("R3 status", {32'd0, rd}, {32'd0, VEC[i][31:0]});
    end
    check("R4 irq after captures", {63'd0, irq}, 64'd1);

    // R5 XOR clear, irq falls only at zero, status write never raises
    reg_write(12'h830, 32'h28);
    reg_read(12'h830, rd); check("R5 xor", {32'd0, rd}, 64'h1);
    check("R5 irq held", {63'd0, irq}, 64'd1);
    reg_write(12'h830, 32'h1);
    check("R5 irq low", {63'd0, irq}, 64'd0);
    reg_write(12'h830, 32'h4);
    reg_read(12'h830, rd); check("R5 set by xor", {32'd0, rd}, 64'h4);
    check("R5 no raise", {63'd0, irq}, 64'd0);
    reg_write(12'h830, 32'h4);

    // R4 / R10 masking
    reg_write(12'h82C, 32'h1);
    snoop(MSG, 1'b1, 3'd4, 32'd0);
    check("R4 masked capture", {63'd0, irq}, 64'd0);
    reg_read(12'h82C, rd); check("R10 mask read", {32'd0, rd}, 64'h1);
    reg_read(12'h830, rd); check("R10 masked bit readable", {32'd0, rd}, 64'h1);
    snoop(MSG, 1'b1, 3'd4, 32'd2);
    check("R4 unmasked capture", {63'd0, irq}, 64'd1);
    reg_write(12'h830, 32'h5);
    check("R5 cleared", {63'd0, irq}, 64'd0);

    // R6 window closed
    reg_write(12'h828, 32'h0);
    snoop(MSG, 1'b1, 3'd4, 32'd1);
    check("R6 claim", {63'd0, in_claim}, 64'd0);
    check("R6 pass", {63'd0, in_pass}, 64'd1);
    reg_read(12'h830, rd); check("R6 status", {32'd0, rd}, 64'd0);

    // R10 unused offset
    reg_read(12'h834, rd); check("R10 unused offset", {32'd0, rd}, 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule